// File: doc/BRIEF.md
# Ethernet Transmit Deferral Timer

This block decides when the transmit side of an Ethernet MAC may start its next frame. It counts bit times on a one-cycle tick input and measures the gap that must pass since the medium last became quiet. The medium becomes quiet either when this station ends a frame or when carrier from another station drops. When a frame request is pending and the selected gap has elapsed, the block raises a one-cycle grant, and the datapath starts the frame.

In half duplex the gap after carrier has two phases. During the first phase (the carrier window), carrier sense makes the block back off. The block then waits for carrier to fall and restarts the whole gap from zero. After the window has closed, carrier is ignored and the frame goes out when the gap ends, even if that causes a collision. When one of this station's frames directly follows its previous one, the shorter back-to-back gap applies. In full duplex carrier is never consulted and only the back-to-back gap is used. The three gap values are configuration inputs in bit times. Typical settings are a 64-bit window, a 96-bit gap after carrier and a 96-bit back-to-back gap. The window value must not exceed the gap after carrier.

Top module: `tx_defer_timer`

## Requirements
- R1: While reset is asserted and after it is released, `tx_grant` is low. The timer leaves reset in the elapsed state, so a request taken at clock edge c is granted in the cycle after edge c+1 when `bit_tick` is high at edge c+1.
- R2: `tx_grant` is high for exactly one cycle and only when a request is pending. A `tx_req` pulse stays pending until it is granted, including a pulse given while a frame is in progress. A request made after the gap has elapsed is granted on the next tick.
- R3: The gap counter advances only at clock edges where `bit_tick` is high. With the tick held low, no grant is issued however long the wait.
- R4: In half duplex with carrier low, after a `tx_end` pulse sampled at edge E, a pending request is granted in the cycle after edge E+`cfg_b2b` (tick high every cycle).
- R5: In half duplex, carrier sampled high at an edge where fewer than `cfg_win` ticks of the gap have been counted makes the block defer. Once carrier is sampled low at edge D, the gap restarts from zero using `cfg_nb2b`, and the grant follows in the cycle after edge D+`cfg_nb2b`.
- R6: In half duplex, carrier that rises once `cfg_win` ticks have been counted is ignored. The grant still comes at the end of the gap in progress.
- R7: In half duplex, carrier sampled high while the gap has elapsed and no grant is issued at that edge makes the block defer as in R5.
- R8: In full duplex, carrier has no effect anywhere. Every gap uses `cfg_b2b`, and a request in the elapsed state is granted on the next tick even with carrier high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| carrier | input | 1 | Carrier sense from the line |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_req | input | 1 | Strobe: a frame is ready to send |
| tx_end | input | 1 | Strobe: this station's frame has ended |
| cfg_win | input | GAP_W | Carrier window (first phase) in bit times |
| cfg_nb2b | input | GAP_W | Gap after carrier in bit times |
| cfg_b2b | input | GAP_W | Back-to-back gap in bit times |
| tx_grant | output | 1 | One-cycle pulse: the next frame may start |

## Verification
Every result is timed from the clock edge that samples its cause. A grant is visible in the cycle after edge E+L, where E is the edge that samples `tx_end`, the carrier drop or (for an elapsed gap) the request, and L is the selected gap (1 for an elapsed gap). The bench numbers the rising edges, drives all stimulus on falling edges, and records which edge index will sample each stimulus. From that index it pushes the edge index at which the grant is due. A monitor compares each grant it sees on a falling edge against the front of that queue. Any grant that arrives early, late, or with no entry queued is a miscompare, and the queue must be empty at the end of each scenario.

// File: rtl/tx_defer_pkg.sv
package tx_defer_pkg;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_TX    = 2'd1,
    ST_GAP   = 2'd2,
    ST_DEFER = 2'd3
  } dt_state_e;

endpackage

// File: rtl/tx_defer_sel.sv
module tx_defer_sel #(
  parameter int GAP_W = 8
) (
  input  logic             full_duplex,
  input  logic             own_b2b,
  input  logic [GAP_W-1:0] cfg_win,
  input  logic [GAP_W-1:0] cfg_nb2b,
  input  logic [GAP_W-1:0] cfg_b2b,
  input  logic [GAP_W-1:0] gap_cnt,
  output logic [GAP_W-1:0] gap_limit,
  output logic             win_open
);

  // Full duplex and own back-to-back traffic use the short gap.
  function automatic logic [GAP_W-1:0] pick_limit(
    input logic fd, input logic b2b,
    input logic [GAP_W-1:0] nb2b_v, input logic [GAP_W-1:0] b2b_v);
    return (fd || b2b) ? b2b_v : nb2b_v;
  endfunction

  // Carrier is honoured only in half duplex and only before the window has closed.
  function automatic logic in_window(
    input logic fd, input logic [GAP_W-1:0] cnt, input logic [GAP_W-1:0] win);
    return !fd && (cnt < win);
  endfunction

  always_comb begin
    gap_limit = pick_limit(full_duplex, own_b2b, cfg_nb2b, cfg_b2b);
    win_open  = in_window(full_duplex, gap_cnt, cfg_win);
  end

endmodule

// File: rtl/tx_defer_cnt.sv
module tx_defer_cnt #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [GAP_W-1:0] limit,
  output logic [GAP_W-1:0] cnt,
  output logic             last_tick
);

  localparam int EXT_W = GAP_W + 1;

  // True when one more tick completes the gap (a limit of 0 acts as 1).
  function automatic logic reaches(
    input logic [GAP_W-1:0] c, input logic [GAP_W-1:0] lim);
    logic [EXT_W-1:0] nxt;
    nxt = {1'b0, c} + EXT_W'(1);
    return nxt >= {1'b0, lim};
  endfunction

  always_comb last_tick = reaches(cnt, limit);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (adv) cnt <= cnt + GAP_W'(1);
  end

endmodule

// File: rtl/tx_defer_req.sv
module tx_defer_req (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_req,
  input  logic grant_fire,
  output logic req_pend
);

  // A strobe on the granting edge is kept for the following frame.
  always_ff @(posedge clk) begin
    if (!rst_n) req_pend <= 1'b0;
    else        req_pend <= (req_pend & ~grant_fire) | tx_req;
  end

endmodule

// File: rtl/tx_defer_timer.sv
module tx_defer_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             carrier,
  input  logic             full_duplex,
  input  logic             tx_req,
  input  logic             tx_end,
  input  logic [GAP_W-1:0] cfg_win,
  input  logic [GAP_W-1:0] cfg_nb2b,
  input  logic [GAP_W-1:0] cfg_b2b,
  output logic             tx_grant
);

  import tx_defer_pkg::*;

  dt_state_e        st_q, st_d;
  logic             own_b2b;
  logic             set_b2b, clr_b2b;
  logic             cnt_clr, cnt_adv;
  logic             grant_fire;
  logic             req_pend;
  logic             win_open;
  logic             last_tick;
  logic             defer_hit;
  logic [GAP_W-1:0] gap_cnt;
  logic [GAP_W-1:0] gap_limit;

  tx_defer_req u_req (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_req     (tx_req),
    .grant_fire (grant_fire),
    .req_pend   (req_pend)
  );

  tx_defer_sel #(.GAP_W(GAP_W)) u_sel (
    .full_duplex (full_duplex),
    .own_b2b     (own_b2b),
    .cfg_win     (cfg_win),
    .cfg_nb2b    (cfg_nb2b),
    .cfg_b2b     (cfg_b2b),
    .gap_cnt     (gap_cnt),
    .gap_limit   (gap_limit),
    .win_open    (win_open)
  );

  tx_defer_cnt #(.GAP_W(GAP_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cnt_clr),
    .adv       (cnt_adv),
    .limit     (gap_limit),
    .cnt       (gap_cnt),
    .last_tick (last_tick)
  );

  // Carrier inside the first phase forces a fresh deferral.
  assign defer_hit = win_open & carrier;

  always_comb begin
    st_d       = st_q;
    cnt_clr    = 1'b0;
    cnt_adv    = 1'b0;
    grant_fire = 1'b0;
    set_b2b    = 1'b0;
    clr_b2b    = 1'b0;
    unique case (st_q)
      ST_READY: begin
        if (bit_tick && req_pend) begin
          grant_fire = 1'b1;
          st_d       = ST_TX;
        end else if (!full_duplex && carrier) begin
          clr_b2b = 1'b1;
          st_d    = ST_DEFER;
        end
      end
      ST_TX: begin
        if (tx_end) begin
          cnt_clr = 1'b1;
          set_b2b = 1'b1;
          st_d    = ST_GAP;
        end
      end
      ST_GAP: begin
        if (defer_hit) begin
          cnt_clr = 1'b1;
          clr_b2b = 1'b1;
          st_d    = ST_DEFER;
        end else if (bit_tick) begin
          if (last_tick) begin
            cnt_clr = 1'b1;
            if (req_pend) begin
              grant_fire = 1'b1;
              st_d       = ST_TX;
            end else begin
              st_d = ST_READY;
            end
          end else begin
            cnt_adv = 1'b1;
          end
        end
      end
      ST_DEFER: begin
        if (full_duplex || !carrier) begin
          cnt_clr = 1'b1;
          st_d    = ST_GAP;
        end
      end
      default: st_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_READY;
      own_b2b  <= 1'b0;
      tx_grant <= 1'b0;
    end else begin
      st_q     <= st_d;
      tx_grant <= grant_fire;
      if (clr_b2b)      own_b2b <= 1'b0;
      else if (set_b2b) own_b2b <= 1'b1;
    end
  end

endmodule

// File: rtl/tx_defer_timer_chk.sv
module tx_defer_timer_chk #(
  parameter int GAP_W = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bit_tick,
  input logic                   carrier,
  input logic                   full_duplex,
  input logic                   tx_grant,
  input logic                   req_pend,
  input logic                   win_open,
  input tx_defer_pkg::dt_state_e st_q,
  input logic [GAP_W-1:0]       gap_cnt
);

  import tx_defer_pkg::*;

  assert_grant_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);

  assert_grant_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> $past(req_pend));

  assert_hold_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && !bit_tick && !win_open) |=> (gap_cnt == $past(gap_cnt)));

  assert_ready_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_READY) |-> (gap_cnt == '0));

  assert_window_defers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && win_open && carrier) |=> (st_q == ST_DEFER && gap_cnt == '0));

  assert_late_carrier_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_GAP && !win_open) |=> (st_q != ST_DEFER));

  assert_full_duplex_no_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full_duplex && st_q != ST_DEFER) |=> (st_q != ST_DEFER));

endmodule

bind tx_defer_timer tx_defer_timer_chk #(.GAP_W(GAP_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_tick    (bit_tick),
  .carrier     (carrier),
  .full_duplex (full_duplex),
  .tx_grant    (tx_grant),
  .req_pend    (req_pend),
  .win_open    (win_open),
  .st_q        (st_q),
  .gap_cnt     (gap_cnt)
);

// File: tb/test_tx_defer_timer.sv
module test_tx_defer_timer;

  localparam int GAP_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             bit_tick = 1'b1;
  logic             carrier = 1'b0;
  logic             full_duplex = 1'b0;
  logic             tx_req = 1'b0;
  logic             tx_end = 1'b0;
  logic [GAP_W-1:0] cfg_win = 8'd64;
  logic [GAP_W-1:0] cfg_nb2b = 8'd96;
  logic [GAP_W-1:0] cfg_b2b = 8'd96;
  logic             tx_grant;

  int nvec = 0;
  int nbad = 0;
  int cyc  = 0;
  bit finished = 1'b0;
  int exp_q[$];
  string exp_tag[$];

  tx_defer_timer #(.GAP_W(GAP_W)) i_tx_defer_timer (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .carrier(carrier),
    .full_duplex(full_duplex), .tx_req(tx_req), .tx_end(tx_end),
    .cfg_win(cfg_win), .cfg_nb2b(cfg_nb2b), .cfg_b2b(cfg_b2b),
    .tx_grant(tx_grant)
  );

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: each grant is compared with the edge index at the queue front.
  always @(negedge clk) begin
    if (rst_n && tx_grant && !finished) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected grant at edge", cyc, -1);
      end else begin
        check(cyc == exp_q[0], exp_tag[0], cyc, exp_q[0]);
        void'(exp_q.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  task automatic expect_at(input int edge_idx, input string tag);
    exp_q.push_back(edge_idx);
    exp_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Returns the index of the edge that samples the strobe.
  task automatic pulse_req(output int e);
    @(negedge clk); e = cyc + 1; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic pulse_end(output int e);
    @(negedge clk); e = cyc + 1; tx_end = 1'b1;
    @(negedge clk); tx_end = 0;
  endtask

  task automatic drained(input string tag);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 20);
    check(1'b0, "watchdog expired", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    int e, d;
    idle(3);
    check(tx_grant == 1'b0, "R1 grant low in reset", tx_grant, 0);
    rst_n = 1'b1;
    idle(2);
    check(tx_grant == 1'b0, "R1 grant low after reset", tx_grant, 0);

    // R1: elapsed after reset, request granted on the next tick.
    pulse_req(e); expect_at(e + 1, "R1 first grant");
    idle(4); drained("R1 first grant seen");

    // R4 with typical settings: back-to-back gap of 96.
    pulse_req(e);
    pulse_end(e); expect_at(e + 96, "R4 b2b gap 96");
    idle(100); drained("R4 b2b gap 96 seen");

    // R5 with typical settings: carrier at the last window tick (63 counted).
    pulse_req(e);
    pulse_end(e); idle(63); carrier = 1'b1;
    idle(6); carrier = 1'b0; d = cyc + 1;
    expect_at(d + 96, "R5 defer then nb2b 96");
    idle(100); drained("R5 defer at 64 seen");

    // Small settings: window 4, gap after carrier 10, back-to-back 6.
    cfg_win = 8'd4; cfg_nb2b = 8'd10; cfg_b2b = 8'd6;

    // R4: half duplex back-to-back.
    pulse_req(e);
    pulse_end(e); expect_at(e + 6, "R4 half b2b");
    idle(10); drained("R4 half b2b seen");

    // R5: carrier at edge E+4, 3 ticks counted, window still open.
    pulse_req(e);
    pulse_end(e); idle(3); carrier = 1'b1;
    idle(8); carrier = 1'b0; d = cyc + 1;
    expect_at(d + 10, "R5 window boundary defer");
    idle(14); drained("R5 window defer seen");

    // R6: carrier at edge E+5, window closed; grant at E+6 regardless.
    pulse_req(e);
    pulse_end(e); expect_at(e + 6, "R6 carrier in part 2 ignored");
    idle(4); carrier = 1'b1;
    idle(6); drained("R6 grant seen");
    carrier = 1'b0;

    // R2: gap elapses with no request, later request granted on next tick.
    pulse_end(e); idle(12);
    check(tx_grant == 1'b0, "R2 no grant without request", tx_grant, 0);
    pulse_req(e); expect_at(e + 1, "R2 late request next tick");
    idle(4); drained("R2 late grant seen");

    // R7: carrier while elapsed and idle defers; request waits for the full gap.
    pulse_end(e); idle(10);
    carrier = 1'b1; idle(2);
    pulse_req(e); idle(5);
    carrier = 1'b0; d = cyc + 1;
    expect_at(d + 10, "R7 idle carrier defers");
    idle(14); drained("R7 grant seen");

    // R8: full duplex, carrier high across the gap.
    full_duplex = 1'b1;
    pulse_req(e);
    pulse_end(e); carrier = 1'b1; expect_at(e + 6, "R8 full duplex b2b");
    idle(10); drained("R8 full duplex grant seen");
    pulse_end(e); idle(10);
    pulse_req(e); expect_at(e + 1, "R8 carrier ignored when elapsed");
    idle(4); drained("R8 elapsed grant seen");
    carrier = 1'b0;

    // R3: tick held low stalls the gap.
    bit_tick = 1'b0;
    pulse_req(e);
    pulse_end(e); idle(20);
    check(tx_grant == 1'b0, "R3 no grant while tick low", tx_grant, 0);
    bit_tick = 1'b1; d = cyc + 1;
    expect_at(d + 5, "R3 gap resumes on ticks");
    idle(10); drained("R3 grant seen");

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule